// File: doc/BRIEF.md
# Bus-Attached Control Register and GPIO Port Block

This peripheral sits on a simple register bus. It holds a bank of 16-bit control words and a 16-line general-purpose I/O port. Software accesses it through word-spaced offsets. A read returns its data in the same cycle as the address. A write takes effect at the next clock edge. Only the low 16 bits of the write data are kept.

The port has three registers:
- a direction register;
- a level register, which can be written through either of two offsets;
- a recorded copy of the last resolved output.

External logic can set or clear individual level bits through strobed input lines. These input updates do not refresh the outputs. After any bus write to the direction or level registers, each output line presents level AND direction. Each line also raises a one-cycle change strobe when its resolved value differs from the value recorded before the write.

The interrupt-related words are plain storage here. An access to an unmapped offset reads as zero, does nothing on write, and raises a one-cycle error pulse.

Top module: `ioport_regblk`

## Requirements
- R1: The words at offsets 0x00, 0x04, 0x10, 0x14, 0x18 and 0x1C read back the last value written to them.
  - A read is `bus_sel`=1 with `bus_we`=0.
  - The data appears on `bus_rdata` in the same cycle.
  - When no read is in progress, `bus_rdata` is 0.
- R2: Every stored word keeps only bits 15:0 of `bus_wdata`. `bus_rdata[31:16]` is always 0.
- R3: A write to offset 0x0C stores the value. If bit 7 of the written value is 1, bits 15 and 6 are also set, so the stored value is the value OR 0x8040.
- R4: Offset 0x08 reads 0x0002 after reset. Writes to it are accepted without error and have no effect.
- R5: Offset 0x20 holds the direction word. It reads back exactly what was written.
- R6: A write to offset 0x24 or to offset 0x28 stores (write data AND current direction) into the level register. A read of either offset returns the level register.
- R7: `line_lvl` changes only in the cycle after a write to 0x20, 0x24 or 0x28. It then equals (level AND direction), using the values those registers hold after that write.
- R8: In the cycle after such a write, `line_chg` bit i is 1 exactly when the new `line_lvl` bit i differs from its previous value. In every other cycle `line_chg` is 0.
- R9: For each line i with `pin_stb[i]`=1, level bit i takes the value of `pin_val[i]` at the clock edge.
  - This update alone leaves `line_lvl` and `line_chg` unchanged.
  - If a direction write happens in the same cycle, it re-evaluates the outputs using the updated level.
- R10: When a bus write to 0x24 or 0x28 occurs in the same cycle as input strobes, the bus value is stored and the strobes are discarded.
- R11: An unmapped access reads as 0 and changes no register. It also sets `bus_err` to 1 for exactly the following cycle.
  - An access is unmapped when address bits 1:0 are nonzero or the offset is above 0x28.
- R12: After reset every register and output is 0, except the word at 0x08, which is 0x0002.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset within the block |
| bus_wdata | input | 32 | Write data (low 16 bits used) |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | One-cycle pulse after an unmapped access |
| pin_stb | input | 16 | Per-line strobe for an external level update |
| pin_val | input | 16 | Level value applied where strobed |
| line_lvl | output | 16 | Registered resolved output level |
| line_chg | output | 16 | One-cycle per-line change strobe |

## Verification
The bench targets several specific corner cases:
- A level write that happens while direction bits are cleared. A design that skipped the mask would store those bits and drive them later.
- Input strobes with no bus write. A design that re-evaluated on them would move `line_lvl` or pulse `line_chg` spuriously.
- An input strobe that collides with a bus level write. A design that lets the strobe win would corrupt the written word.
- Power writes with bit 7 set and with bit 7 clear. These catch a missing or always-on 0x8040 force.
- Misaligned and out-of-range offsets. These catch aliasing onto real registers and a missing or stretched error pulse.

// File: rtl/ioport_pkg.sv
package ioport_pkg;
  localparam int DW      = 16;
  localparam int LINES   = 16;
  localparam int NREGS   = 11;
  localparam int IDX_W   = $clog2(NREGS);
  localparam int NCTL    = 8;

  localparam int IX_MODE = 0;
  localparam int IX_CFG  = 1;
  localparam int IX_STAT = 2;
  localparam int IX_PWR  = 3;
  localparam int IX_CLK  = 4;
  localparam int IX_IRQ  = 5;
  localparam int IX_MSK  = 6;
  localparam int IX_IST  = 7;
  localparam int IX_DIR  = 8;
  localparam int IX_LVW  = 9;
  localparam int IX_LVR  = 10;

  localparam logic [DW-1:0] STAT_RESET = 16'h0002;
  localparam logic [DW-1:0] PWR_FORCE  = 16'h8040;

  function automatic logic [DW-1:0] f_power_fix(input logic [DW-1:0] v);
    return v[7] ? (v | PWR_FORCE) : v;
  endfunction

  function automatic logic [LINES-1:0] f_resolve(input logic [LINES-1:0] lvl,
                                                 input logic [LINES-1:0] dir);
    return lvl & dir;
  endfunction

  function automatic logic [LINES-1:0] f_merge_pins(input logic [LINES-1:0] lvl,
                                                    input logic [LINES-1:0] stb,
                                                    input logic [LINES-1:0] val);
    return (lvl & ~stb) | (val & stb);
  endfunction
endpackage

// File: rtl/ioport_decode.sv
module ioport_decode
  import ioport_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NREGS-1:0]  wr_vec,
  output logic              rd_en,
  output logic [IDX_W-1:0]  hit_idx,
  output logic              hit_none
);
  logic [ADDR_W-3:0] word;
  logic              in_map;

  assign word     = bus_addr[ADDR_W-1:2];
  assign in_map   = (bus_addr[1:0] == 2'b00) && (word < (ADDR_W-2)'(NREGS));
  assign hit_none = bus_sel && !in_map;
  assign hit_idx  = in_map ? word[IDX_W-1:0] : '0;
  assign rd_en    = bus_sel && !bus_we && in_map;

  for (genvar i = 0; i < NREGS; i++) begin : g_wr
    assign wr_vec[i] = bus_sel && bus_we && in_map && (word == (ADDR_W-2)'(i));
  end
endmodule

// File: rtl/ioport_ctl_bank.sv
module ioport_ctl_bank
  import ioport_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCTL-1:0]          wr_en,
  input  logic [DW-1:0]            wdata,
  output logic [NCTL-1:0][DW-1:0]  vals
);
  for (genvar i = 0; i < NCTL; i++) begin : g_word
    if (i == IX_STAT) begin : g_status
      logic unused_wr;
      assign unused_wr = wr_en[i];
      assign vals[i]   = STAT_RESET;
    end else if (i == IX_PWR) begin : g_power
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (wr_en[i]) q <= f_power_fix(wdata);
      end
      assign vals[i] = q;
    end else begin : g_plain
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (wr_en[i]) q <= wdata;
      end
      assign vals[i] = q;
    end
  end
endmodule

// File: rtl/ioport_gpio.sv
module ioport_gpio
  import ioport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dir,
  input  logic             wr_lvl,
  input  logic [DW-1:0]    wdata,
  input  logic [LINES-1:0] pin_stb,
  input  logic [LINES-1:0] pin_val,
  output logic [LINES-1:0] dir_q,
  output logic [LINES-1:0] lvl_q,
  output logic [LINES-1:0] line_lvl,
  output logic [LINES-1:0] line_chg,
  output logic             upd
);
  logic [LINES-1:0] dir_d, lvl_d, res_d;

  assign dir_d = wr_dir ? wdata[LINES-1:0] : dir_q;
  assign lvl_d = wr_lvl ? (wdata[LINES-1:0] & dir_q)
                        : f_merge_pins(lvl_q, pin_stb, pin_val);
  assign res_d = f_resolve(lvl_d, dir_d);
  assign upd   = wr_dir || wr_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      lvl_q <= '0;
    end else begin
      dir_q <= dir_d;
      lvl_q <= lvl_d;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic prev_q, chg_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        chg_q  <= 1'b0;
      end else begin
        chg_q <= upd && (res_d[i] != prev_q);
        if (upd) prev_q <= res_d[i];
      end
    end
    assign line_lvl[i] = prev_q;
    assign line_chg[i] = chg_q;
  end
endmodule

// File: rtl/ioport_regblk.sv
module ioport_regblk
  import ioport_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic [LINES-1:0]  pin_stb,
  input  logic [LINES-1:0]  pin_val,
  output logic [LINES-1:0]  line_lvl,
  output logic [LINES-1:0]  line_chg
);
  logic [NREGS-1:0]         wr_vec;
  logic                     rd_en;
  logic [IDX_W-1:0]         hit_idx;
  logic                     hit_none;
  logic [NCTL-1:0][DW-1:0]  ctl_vals;
  logic [LINES-1:0]         dir_q, lvl_q;
  logic                     gpio_upd;
  logic [DW-1:0]            wdata16;
  logic [DW-1:0]            pwr_val;
  logic [DW-1:0]            rd_word;
  logic                     unused_hi;

  assign wdata16   = bus_wdata[DW-1:0];
  assign unused_hi = ^bus_wdata[31:DW];
  assign pwr_val   = ctl_vals[IX_PWR];

  ioport_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .wr_vec  (wr_vec),
    .rd_en   (rd_en),
    .hit_idx (hit_idx),
    .hit_none(hit_none)
  );

  ioport_ctl_bank u_ctl (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_vec[NCTL-1:0]),
    .wdata(wdata16),
    .vals (ctl_vals)
  );

  ioport_gpio u_gpio (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_dir  (wr_vec[IX_DIR]),
    .wr_lvl  (wr_vec[IX_LVW] || wr_vec[IX_LVR]),
    .wdata   (wdata16),
    .pin_stb (pin_stb),
    .pin_val (pin_val),
    .dir_q   (dir_q),
    .lvl_q   (lvl_q),
    .line_lvl(line_lvl),
    .line_chg(line_chg),
    .upd     (gpio_upd)
  );

  always_comb begin
    rd_word = '0;
    if (hit_idx < IDX_W'(NCTL))          rd_word = ctl_vals[hit_idx[2:0]];
    else if (hit_idx == IDX_W'(IX_DIR))  rd_word = dir_q;
    else                                 rd_word = lvl_q;
  end

  assign bus_rdata = rd_en ? {{(32-DW){1'b0}}, rd_word} : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) bus_err <= 1'b0;
    else        bus_err <= hit_none;
  end
endmodule

// File: rtl/ioport_regblk_chk.sv
module ioport_regblk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        bus_err,
  input logic [15:0] line_lvl,
  input logic [15:0] line_chg,
  input logic        hit_none,
  input logic        gpio_upd,
  input logic [15:0] pwr_val
);
  p_err_after_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hit_none |=> bus_err);
  p_err_only_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(hit_none));
  p_miss_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hit_none |-> (bus_rdata == 32'h0));
  p_rdata_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:16] == 16'h0);
  p_pwr_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 12'h00C && bus_wdata[7]) |=> (pwr_val[15] && pwr_val[6]));
  p_status_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == 12'h008) |-> (bus_rdata == 32'h2));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gpio_upd |=> $stable(line_lvl));
  p_chg_delta_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_upd |=> (line_chg == (line_lvl ^ $past(line_lvl))));
  p_chg_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gpio_upd |=> (line_chg == 16'h0));
endmodule

bind ioport_regblk ioport_regblk_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .bus_err  (bus_err),
  .line_lvl (line_lvl),
  .line_chg (line_chg),
  .hit_none (hit_none),
  .gpio_upd (gpio_upd),
  .pwr_val  (pwr_val)
);

// File: tb/tb_ioport_regblk.sv
module tb_ioport_regblk;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [15:0] pin_stb = 0, pin_val = 0;
  logic [15:0] line_lvl, line_chg;

  int checks = 0, errors = 0;

  logic [15:0] m_reg [0:7];
  logic [15:0] m_dir, m_lvl, m_out, m_chg;
  logic        m_err;

  always #5 clk = ~clk;

  ioport_regblk dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .pin_stb(pin_stb), .pin_val(pin_val),
    .line_lvl(line_lvl), .line_chg(line_chg)
  );

  function automatic bit mapped(input logic [11:0] a);
    return (a[1:0] == 2'b00) && (a[11:2] <= 10'd10);
  endfunction

  function automatic logic [15:0] pwr_rule(input logic [15:0] v);
    logic [15:0] r = v;
    if (v[7]) begin r[15] = 1'b1; r[6] = 1'b1; end
    return r;
  endfunction

  function automatic logic [15:0] mread(input logic [11:0] a);
    if (!mapped(a)) return 16'h0;
    case (a[5:2])
      4'd2:       return 16'h0002;
      4'd8:       return m_dir;
      4'd9, 4'd10: return m_lvl;
      default:    return m_reg[a[4:2]];
    endcase
  endfunction

  function automatic string rtag(input logic [11:0] a);
    if (!mapped(a)) return "R11";
    case (a[5:2])
      4'd2: return "R4";
      4'd3: return "R3";
      4'd8: return "R5";
      4'd9, 4'd10: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit sel, input bit we, input logic [11:0] a,
                      input logic [31:0] wd, input logic [15:0] stb, input logic [15:0] val);
    logic [15:0] w, n_dir, n_lvl, res;
    bit upd, lvl_wr;
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd;
    pin_stb = stb; pin_val = val;
    #1;
    chk(rtag(a), bus_rdata, (sel && !we) ? {16'h0, mread(a)} : 32'h0);
    w = wd[15:0];
    n_dir = m_dir; n_lvl = m_lvl;
    lvl_wr = sel && we && mapped(a) && (a[5:2] == 4'd9 || a[5:2] == 4'd10);
    upd = lvl_wr || (sel && we && mapped(a) && a[5:2] == 4'd8);
    n_lvl = (m_lvl & ~stb) | (val & stb);
    if (sel && we && mapped(a)) begin
      case (a[5:2])
        4'd2: ;
        4'd3: m_reg[3] = pwr_rule(w);
        4'd8: n_dir = w;
        4'd9, 4'd10: n_lvl = w & m_dir;
        default: m_reg[a[4:2]] = w;
      endcase
    end
    @(posedge clk); @(negedge clk);
    m_err = sel && !mapped(a);
    m_dir = n_dir; m_lvl = n_lvl;
    if (upd) begin
      res = n_lvl & n_dir;
      m_chg = res ^ m_out;
      m_out = res;
    end else m_chg = 16'h0;
    chk("R7 line_lvl", {16'h0, line_lvl}, {16'h0, m_out});
    chk("R8 line_chg", {16'h0, line_chg}, {16'h0, m_chg});
    chk("R11 bus_err", {31'h0, bus_err}, {31'h0, m_err});
    bus_sel = 0; bus_we = 0; pin_stb = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(1, 1, a, d, 16'h0, 16'h0);
  endtask

  task automatic rd_expect(input string tag, input logic [11:0] a, input logic [15:0] e);
    bus_sel = 1; bus_we = 0; bus_addr = a; #1;
    chk(tag, bus_rdata, {16'h0, e});
    step(1, 0, a, 32'h0, 16'h0, 16'h0);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 8; i++) m_reg[i] = 16'h0;
    m_dir = 0; m_lvl = 0; m_out = 0; m_chg = 0; m_err = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    chk("R12 line_lvl", {16'h0, line_lvl}, 32'h0);
    chk("R12 line_chg", {16'h0, line_chg}, 32'h0);
    chk("R12 bus_err", {31'h0, bus_err}, 32'h0);
    for (int i = 0; i <= 10; i++)
      rd_expect((i == 2) ? "R12 status" : "R12 reg", 12'(i * 4), (i == 2) ? 16'h0002 : 16'h0);
    // R2 truncation, R1 plain storage
    wr(12'h000, 32'hDEAD_1234);
    rd_expect("R2 truncate", 12'h000, 16'h1234);
    wr(12'h01C, 32'h0000_A5A5);
    rd_expect("R1 isr", 12'h01C, 16'hA5A5);
    // R3 power force
    wr(12'h00C, 32'h0000_0080);
    rd_expect("R3 force", 12'h00C, 16'h80C0);
    wr(12'h00C, 32'h0000_0001);
    rd_expect("R3 no force", 12'h00C, 16'h0001);
    // R4 status write ignored
    wr(12'h008, 32'h0000_FFFF);
    rd_expect("R4 status", 12'h008, 16'h0002);
    chk("R4 no err", {31'h0, bus_err}, 32'h0);
    // R5/R6/R7/R8
    wr(12'h020, 32'h0000_00FF);
    rd_expect("R5 dir", 12'h020, 16'h00FF);
    wr(12'h024, 32'h0000_FFFF);
    rd_expect("R6 masked", 12'h028, 16'h00FF);
    wr(12'h028, 32'h0000_0F0F);
    rd_expect("R6 alias", 12'h024, 16'h000F);
    chk("R7 out", {16'h0, line_lvl}, 32'h0000_000F);
    // R9 strobes update level, no re-evaluation
    step(0, 0, 12'h0, 0, 16'hFF00, 16'hFF00);
    chk("R9 out held", {16'h0, line_lvl}, 32'h0000_000F);
    chk("R9 no chg", {16'h0, line_chg}, 32'h0);
    rd_expect("R9 level", 12'h024, 16'hFF0F);
    step(1, 1, 12'h020, 32'h0000_FFFF, 16'h0000, 16'h0000);
    chk("R8 chg", {16'h0, line_chg}, 32'h0000_FF00);
    chk("R7 out2", {16'h0, line_lvl}, 32'h0000_FF0F);
    // R10 collision: bus wins
    step(1, 1, 12'h024, 32'h0000_1234, 16'hFFFF, 16'hFFFF);
    rd_expect("R10 bus wins", 12'h028, 16'h1234);
    // R11 unmapped
    step(1, 1, 12'h02C, 32'h0000_FFFF, 16'h0, 16'h0);
    chk("R11 err", {31'h0, bus_err}, 32'h1);
    step(1, 1, 12'h005, 32'h0000_FFFF, 16'h0, 16'h0);
    rd_expect("R11 no alias", 12'h004, 16'h0000);
    rd_expect("R11 miss read", 12'hFFC, 16'h0000);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      logic [15:0] s;
      a = ($urandom % 8 != 0) ? 12'(($urandom % 11) * 4) : 12'($urandom);
      s = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0;
      step(($urandom % 4) != 0, $urandom % 2 == 1, a, $urandom, s, 16'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule